// File: doc/BRIEF.md
# Runahead Checkpoint Controller

This controller lets an out-of-order core keep working while a long-latency memory access blocks retirement. When the oldest entry of the reorder buffer is a load or store that missed in the cache, the controller takes a snapshot of the architectural state and switches the core into a speculative mode. It copies the architectural register values and the rename map into a private checkpoint store, one register per cycle, and captures the fetch address of the blocking access, the return address stack and the global branch history in a single cycle. During speculative mode the core runs ahead to warm the caches, and nothing it does may reach architectural state.

While in speculative mode the controller keeps one invalid ("poison") bit per physical register. The destination of the blocking access is marked invalid at entry. The issue stage asks the controller about each instruction. An instruction with an invalid source is not executed and its destination becomes invalid. A load that misses again also yields an invalid destination. A clean result clears the bit of its destination. A branch with an invalid source cannot use its own outcome and has to follow its predicted path.

When the miss data comes back, the controller replays the checkpoint into the register file and the rename map, again one register per cycle. In the last restore cycle it presents the saved return address stack and branch history and redirects fetch to the blocking access. At the same edge every poison bit is cleared.

Top module: `runahead_ctrl`

## Requirements
- R1: Speculative mode (`runahead`=1) is entered only from normal mode, and only when `head_vld`, `head_is_mem` and `head_miss` are all 1 at a clock edge. `runahead` rises at that edge.
- R2: After entry there are exactly NUM_ARCH save cycles. In each one `busy`=1 and `arf_rd_idx` steps through 0..NUM_ARCH-1, one per cycle. After the last one `busy` returns to 0 and the block stays in speculative mode.
- R3: `commit_block` is 1 in every cycle that `runahead` is 1 (save, speculative run and restore) and 0 in normal mode.
- R4: The physical register given by `head_dst` at the entry edge is invalid during speculative mode.
- R5: In speculative mode, an issued op with an invalid source has `iss_skip`=1. An issued op that writes (`iss_wr_dst`=1) marks its destination invalid if it was skipped or if `iss_ld_miss`=1, and marks it valid otherwise. In normal mode `iss_skip`=0.
- R6: `br_use_pred`=1 exactly when an issued op has `iss_is_br`=1 and is skipped.
- R7: A `mem_fill` pulse in speculative mode starts NUM_ARCH restore cycles. In each one `rst_wr_en`=1 and `rst_wr_idx` steps from 0 upward. `rst_wr_data` and `rst_map_phys` carry the values that `arf_rd_data` and `map_rd_data` had for that index during the save.
- R8: In the last restore cycle, and in no other cycle, `redirect_vld`=1. In that cycle `redirect_pc`, `ras_restore` and `ghr_restore` equal the `head_pc`, `ras_in` and `ghr_in` that were sampled at the entry edge. The next cycle is in normal mode.
- R9: On exit every invalid bit is cleared. After returning to normal mode, a later entry does not see invalid bits left over from an earlier episode.
- R10: A `mem_fill` in normal mode is ignored, and the block stays in normal mode.
- R11: A further miss at the reorder-buffer head during speculative mode does not start a new save, and it does not change the saved redirect address.
- R12: A `mem_fill` that arrives during the save cycles is held. The restore cycles begin right after the last save cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_vld | input | 1 | The reorder-buffer head entry is valid |
| head_is_mem | input | 1 | The head entry is a load or store |
| head_miss | input | 1 | The head entry missed in the cache |
| head_pc | input | PC_W | Fetch address of the head entry |
| head_dst | input | PIDX_W | Physical destination of the head entry |
| mem_fill | input | 1 | The miss data has returned |
| arf_rd_idx | output | AIDX_W | Architectural register read during save |
| arf_rd_data | input | XLEN | Value of the register at `arf_rd_idx` |
| map_rd_data | input | PIDX_W | Rename-map entry of the register at `arf_rd_idx` |
| ras_in | input | RAS_N*PC_W | Current return address stack contents |
| ghr_in | input | GHR_W | Current global branch history |
| iss_vld | input | 1 | An op is issuing |
| iss_src0 | input | PIDX_W | First physical source |
| iss_src1 | input | PIDX_W | Second physical source |
| iss_dst | input | PIDX_W | Physical destination |
| iss_wr_dst | input | 1 | The op writes `iss_dst` |
| iss_is_br | input | 1 | The op is a branch |
| iss_ld_miss | input | 1 | The op is a load that missed |
| iss_skip | output | 1 | Do not execute the op (it has an invalid source) |
| br_use_pred | output | 1 | The branch must keep its predicted path |
| runahead | output | 1 | The block is in speculative mode |
| busy | output | 1 | A save or restore copy is in progress |
| commit_block | output | 1 | Architectural updates are inhibited |
| rst_wr_en | output | 1 | Restore write strobe |
| rst_wr_idx | output | AIDX_W | Architectural register being restored |
| rst_wr_data | output | XLEN | Checkpointed register value |
| rst_map_phys | output | PIDX_W | Checkpointed rename-map entry |
| redirect_vld | output | 1 | Restart fetch; the history restore is valid |
| redirect_pc | output | PC_W | Address of the blocking access |
| ras_restore | output | RAS_N*PC_W | Saved return address stack |
| ghr_restore | output | GHR_W | Saved branch history |

## Verification
The issue-side results `iss_skip` and `br_use_pred` are combinational. They are due in the same cycle as the op, so the bench drives each op at the falling edge and samples them a moment later. Mode changes take effect one rising edge after their trigger. The save sequence covers the NUM_ARCH cycles that follow the entry edge. Restore data, the index and `redirect_vld` are valid during the restore cycles themselves, with the redirect in the last of them. The bench counts cycles from each trigger edge and samples every expected value at the falling edge of the cycle in which it is due. Poison-bit updates are compared with a bench model that is updated only after the edge that commits them.

// File: rtl/ra_pkg.sv
package ra_pkg;
  typedef enum logic [1:0] {
    RA_NORMAL  = 2'd0,
    RA_SAVE    = 2'd1,
    RA_RUN     = 2'd2,
    RA_RESTORE = 2'd3
  } ra_state_e;
endpackage

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm
  import ra_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  localparam int AIDX_W = $clog2(NUM_ARCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_i,
  input  logic              fill_i,
  output ra_state_e         state_o,
  output logic [AIDX_W-1:0] step_o,
  output logic              last_o
);
  localparam logic [AIDX_W-1:0] LastStep = AIDX_W'(NUM_ARCH - 1);

  ra_state_e         state_q, state_d;
  logic [AIDX_W-1:0] step_q, step_d;
  logic              step_en;
  logic              pend_q, pend_d;
  logic              last;

  assign last = (step_q == LastStep);

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    pend_d  = pend_q;
    step_en = 1'b0;
    unique case (state_q)
      RA_NORMAL: begin
        pend_d = 1'b0;
        if (enter_i) begin
          state_d = RA_SAVE;
          step_d  = '0;
          step_en = 1'b1;
        end
      end
      RA_SAVE: begin
        step_en = 1'b1;
        if (fill_i) pend_d = 1'b1;
        if (last) begin
          step_d  = '0;
          pend_d  = 1'b0;
          state_d = (pend_q || fill_i) ? RA_RESTORE : RA_RUN;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      RA_RUN: begin
        if (fill_i) begin
          state_d = RA_RESTORE;
          step_d  = '0;
          step_en = 1'b1;
        end
      end
      RA_RESTORE: begin
        step_en = 1'b1;
        if (last) begin
          state_d = RA_NORMAL;
          step_d  = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      default: state_d = RA_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RA_NORMAL;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  assign state_o = state_q;
  assign step_o  = step_q;
  assign last_o  = last;
endmodule

// File: rtl/ra_ckpt_store.sv
module ra_ckpt_store #(
  parameter int NUM_ARCH = 32,
  parameter int XLEN     = 32,
  parameter int PIDX_W   = 7,
  parameter int PC_W     = 32,
  parameter int GHR_W    = 16,
  parameter int RAS_W    = 128,
  localparam int AIDX_W  = $clog2(NUM_ARCH)
) (
  input  logic              clk,
  input  logic              snap_en,
  input  logic [PC_W-1:0]   snap_pc,
  input  logic [RAS_W-1:0]  snap_ras,
  input  logic [GHR_W-1:0]  snap_ghr,
  input  logic              cap_en,
  input  logic [AIDX_W-1:0] cap_idx,
  input  logic [XLEN-1:0]   cap_data,
  input  logic [PIDX_W-1:0] cap_map,
  input  logic [AIDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]   rd_data,
  output logic [PIDX_W-1:0] rd_map,
  output logic [PC_W-1:0]   pc_o,
  output logic [RAS_W-1:0]  ras_o,
  output logic [GHR_W-1:0]  ghr_o
);
  logic [XLEN-1:0]   data_mem [NUM_ARCH];
  logic [PIDX_W-1:0] map_mem  [NUM_ARCH];
  logic [PC_W-1:0]   pc_q;
  logic [RAS_W-1:0]  ras_q;
  logic [GHR_W-1:0]  ghr_q;

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_entry
    logic wr_here;
    assign wr_here = cap_en && (cap_idx == AIDX_W'(g));
    always_ff @(posedge clk) begin
      if (wr_here) begin
        data_mem[g] <= cap_data;
        map_mem[g]  <= cap_map;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (snap_en) begin
      pc_q  <= snap_pc;
      ras_q <= snap_ras;
      ghr_q <= snap_ghr;
    end
  end

  assign rd_data = data_mem[rd_idx];
  assign rd_map  = map_mem[rd_idx];
  assign pc_o    = pc_q;
  assign ras_o   = ras_q;
  assign ghr_o   = ghr_q;
endmodule

// File: rtl/ra_poison_bits.sv
module ra_poison_bits #(
  parameter int NUM_PHYS = 128,
  localparam int PIDX_W  = $clog2(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              mark_en,
  input  logic [PIDX_W-1:0] mark_idx,
  input  logic              upd_en,
  input  logic [PIDX_W-1:0] upd_idx,
  input  logic              upd_val,
  input  logic [PIDX_W-1:0] src0,
  input  logic [PIDX_W-1:0] src1,
  output logic              src0_bad,
  output logic              src1_bad
);
  logic [NUM_PHYS-1:0] bits_q, bits_d;
  logic                bits_en;

  assign bits_en = clr_all || mark_en || upd_en;

  always_comb begin
    bits_d = bits_q;
    if (upd_en)  bits_d[upd_idx]  = upd_val;
    if (mark_en) bits_d[mark_idx] = 1'b1;
    if (clr_all) bits_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (bits_en) begin
      bits_q <= bits_d;
    end
  end

  assign src0_bad = bits_q[src0];
  assign src1_bad = bits_q[src1];
endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl
  import ra_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 128,
  parameter int XLEN     = 32,
  parameter int PC_W     = 32,
  parameter int GHR_W    = 16,
  parameter int RAS_N    = 4,
  localparam int AIDX_W  = $clog2(NUM_ARCH),
  localparam int PIDX_W  = $clog2(NUM_PHYS),
  localparam int RAS_W   = RAS_N * PC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_vld,
  input  logic              head_is_mem,
  input  logic              head_miss,
  input  logic [PC_W-1:0]   head_pc,
  input  logic [PIDX_W-1:0] head_dst,
  input  logic              mem_fill,
  output logic [AIDX_W-1:0] arf_rd_idx,
  input  logic [XLEN-1:0]   arf_rd_data,
  input  logic [PIDX_W-1:0] map_rd_data,
  input  logic [RAS_W-1:0]  ras_in,
  input  logic [GHR_W-1:0]  ghr_in,
  input  logic              iss_vld,
  input  logic [PIDX_W-1:0] iss_src0,
  input  logic [PIDX_W-1:0] iss_src1,
  input  logic [PIDX_W-1:0] iss_dst,
  input  logic              iss_wr_dst,
  input  logic              iss_is_br,
  input  logic              iss_ld_miss,
  output logic              iss_skip,
  output logic              br_use_pred,
  output logic              runahead,
  output logic              busy,
  output logic              commit_block,
  output logic              rst_wr_en,
  output logic [AIDX_W-1:0] rst_wr_idx,
  output logic [XLEN-1:0]   rst_wr_data,
  output logic [PIDX_W-1:0] rst_map_phys,
  output logic              redirect_vld,
  output logic [PC_W-1:0]   redirect_pc,
  output logic [RAS_W-1:0]  ras_restore,
  output logic [GHR_W-1:0]  ghr_restore
);
  ra_state_e         state;
  logic [AIDX_W-1:0] step;
  logic              last;
  logic              enter, in_save, in_restore, in_ra, leave;
  logic              bad0, bad1, any_bad;

  // Entry qualifies only from normal mode; later misses are ignored.
  assign enter      = (state == RA_NORMAL) && head_vld && head_is_mem && head_miss;
  assign in_save    = (state == RA_SAVE);
  assign in_restore = (state == RA_RESTORE);
  assign in_ra      = (state != RA_NORMAL);
  assign leave      = in_restore && last;

  ra_mode_fsm #(.NUM_ARCH(NUM_ARCH)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .enter_i (enter),
    .fill_i  (mem_fill),
    .state_o (state),
    .step_o  (step),
    .last_o  (last)
  );

  ra_ckpt_store #(
    .NUM_ARCH(NUM_ARCH), .XLEN(XLEN), .PIDX_W(PIDX_W),
    .PC_W(PC_W), .GHR_W(GHR_W), .RAS_W(RAS_W)
  ) u_store (
    .clk      (clk),
    .snap_en  (enter),
    .snap_pc  (head_pc),
    .snap_ras (ras_in),
    .snap_ghr (ghr_in),
    .cap_en   (in_save),
    .cap_idx  (step),
    .cap_data (arf_rd_data),
    .cap_map  (map_rd_data),
    .rd_idx   (step),
    .rd_data  (rst_wr_data),
    .rd_map   (rst_map_phys),
    .pc_o     (redirect_pc),
    .ras_o    (ras_restore),
    .ghr_o    (ghr_restore)
  );

  ra_poison_bits #(.NUM_PHYS(NUM_PHYS)) u_poison (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (leave),
    .mark_en  (enter),
    .mark_idx (head_dst),
    .upd_en   (in_ra && iss_vld && iss_wr_dst),
    .upd_idx  (iss_dst),
    .upd_val  (any_bad || iss_ld_miss),
    .src0     (iss_src0),
    .src1     (iss_src1),
    .src0_bad (bad0),
    .src1_bad (bad1)
  );

  assign any_bad      = bad0 || bad1;
  assign iss_skip     = in_ra && iss_vld && any_bad;
  assign br_use_pred  = iss_skip && iss_is_br;
  assign arf_rd_idx   = in_save ? step : '0;
  assign rst_wr_en    = in_restore;
  assign rst_wr_idx   = in_restore ? step : '0;
  assign redirect_vld = leave;
  assign runahead     = in_ra;
  assign busy         = in_save || in_restore;
  assign commit_block = in_ra;
endmodule

// File: rtl/ra_ctrl_checker.sv
module ra_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic head_vld,
  input logic head_is_mem,
  input logic head_miss,
  input logic mem_fill,
  input logic runahead,
  input logic busy,
  input logic commit_block,
  input logic rst_wr_en,
  input logic redirect_vld,
  input logic iss_skip,
  input logic br_use_pred
);
  assert_entry_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!runahead && !(head_vld && head_is_mem && head_miss)) |=> !runahead);

  assert_busy_in_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> runahead);

  assert_commit_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr_en |-> commit_block);

  assert_skip_only_ra_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_skip |-> runahead);

  assert_branch_pred_R6: assert property (@(posedge clk) disable iff (!rst_n)
    br_use_pred |-> iss_skip);

  assert_restore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr_en |-> busy);

  assert_redirect_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |=> !runahead);

  assert_fill_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!runahead && mem_fill && !head_miss) |=> !runahead);
endmodule

bind runahead_ctrl ra_ctrl_checker u_ra_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .head_vld     (head_vld),
  .head_is_mem  (head_is_mem),
  .head_miss    (head_miss),
  .mem_fill     (mem_fill),
  .runahead     (runahead),
  .busy         (busy),
  .commit_block (commit_block),
  .rst_wr_en    (rst_wr_en),
  .redirect_vld (redirect_vld),
  .iss_skip     (iss_skip),
  .br_use_pred  (br_use_pred)
);

// File: tb/runahead_ctrl_bench.sv
`timescale 1ns/1ps
module runahead_ctrl_bench;
  localparam int NA = 32, NP = 128, XL = 32, PW = 32, GW = 16, RN = 4;
  localparam int AW = 5, PIW = 7, RW = RN * PW;

  logic clk, rst_n;
  logic head_vld, head_is_mem, head_miss, mem_fill;
  logic [PW-1:0] head_pc;
  logic [PIW-1:0] head_dst;
  logic [AW-1:0] arf_rd_idx;
  logic [XL-1:0] arf_rd_data;
  logic [PIW-1:0] map_rd_data;
  logic [RW-1:0] ras_in;
  logic [GW-1:0] ghr_in;
  logic iss_vld, iss_wr_dst, iss_is_br, iss_ld_miss;
  logic [PIW-1:0] iss_src0, iss_src1, iss_dst;
  logic iss_skip, br_use_pred, runahead, busy, commit_block;
  logic rst_wr_en, redirect_vld;
  logic [AW-1:0] rst_wr_idx;
  logic [XL-1:0] rst_wr_data;
  logic [PIW-1:0] rst_map_phys;
  logic [PW-1:0] redirect_pc;
  logic [RW-1:0] ras_restore;
  logic [GW-1:0] ghr_restore;

  logic [XL-1:0]  arf_m [NA];
  logic [PIW-1:0] map_m [NA];
  logic [XL-1:0]  sv_arf [NA];
  logic [PIW-1:0] sv_map [NA];
  logic [NP-1:0]  pm;
  int n_run, n_fail, cyc;

  assign arf_rd_data = arf_m[arf_rd_idx];
  assign map_rd_data = map_m[arf_rd_idx];

  runahead_ctrl u_runahead_ctrl (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic exp_skip(input logic [NP-1:0] m, input logic [PIW-1:0] a,
                                    input logic [PIW-1:0] b);
    return m[a] | m[b];
  endfunction

  task automatic idle_issue();
    iss_vld = 0; iss_wr_dst = 0; iss_is_br = 0; iss_ld_miss = 0;
    iss_src0 = '0; iss_src1 = '0; iss_dst = '0;
  endtask

  task automatic probe(input logic [PIW-1:0] r, input logic exp, input string req);
    iss_vld = 1; iss_wr_dst = 0; iss_src0 = r; iss_src1 = r;
    #1;
    chk(iss_skip === exp, req, "probe skip", 128'(iss_skip), 128'(exp));
    idle_issue();
  endtask

  task automatic episode(input bit early_fill, input int n_ops);
    logic [PW-1:0] pc0;
    logic [RW-1:0] ras0;
    logic [GW-1:0] ghr0;
    logic [PIW-1:0] hd;
    for (int i = 0; i < NA; i++) begin
      arf_m[i] = $urandom;
      map_m[i] = PIW'($urandom);
      sv_arf[i] = arf_m[i];
      sv_map[i] = map_m[i];
    end
    pc0 = $urandom; ras0 = {$urandom, $urandom, $urandom, $urandom};
    ghr0 = GW'($urandom); hd = PIW'($urandom % 16);
    head_pc = pc0; ras_in = ras0; ghr_in = ghr0; head_dst = hd;
    head_vld = 1; head_is_mem = 1; head_miss = 1;
    tick();
    head_vld = 0; head_miss = 0;
    head_pc = ~pc0; ras_in = ~ras0; ghr_in = ~ghr0;
    pm = '0; pm[hd] = 1'b1;
    for (int i = 0; i < NA; i++) begin
      if (early_fill && i == 5) mem_fill = 1;
      #1;
      chk(busy === 1 && runahead === 1, "R2", "save busy", 128'({busy, runahead}), 128'(3));
      chk(arf_rd_idx === AW'(i), "R2", "save idx", 128'(arf_rd_idx), 128'(i));
      chk(commit_block === 1, "R3", "commit block in save", 128'(commit_block), 128'(1));
      tick();
      mem_fill = 0;
    end
    if (!early_fill) begin
      #1;
      chk(busy === 0 && runahead === 1, "R2", "after save", 128'({busy, runahead}), 128'(1));
      chk(commit_block === 1, "R3", "commit block in run", 128'(commit_block), 128'(1));
      for (int i = 0; i < NA; i++) arf_m[i] = ~arf_m[i];
      probe(hd, 1'b1, "R4");
      for (int k = 0; k < n_ops; k++) begin
        logic e;
        iss_vld = 1;
        iss_src0 = PIW'($urandom % 16); iss_src1 = PIW'($urandom % 16);
        iss_dst = PIW'($urandom % 16); iss_wr_dst = 1'($urandom);
        iss_is_br = 1'($urandom); iss_ld_miss = ($urandom % 4) == 0;
        e = exp_skip(pm, iss_src0, iss_src1);
        #1;
        chk(iss_skip === e, "R5", "skip", 128'(iss_skip), 128'(e));
        chk(br_use_pred === (e & iss_is_br), "R6", "branch pred", 128'(br_use_pred),
            128'(e & iss_is_br));
        tick();
        if (iss_wr_dst) pm[iss_dst] = e | iss_ld_miss;
        idle_issue();
      end
      head_vld = 1; head_is_mem = 1; head_miss = 1;
      for (int k = 0; k < 3; k++) begin
        tick();
        #1;
        chk(busy === 0 && runahead === 1, "R11", "no nested save", 128'({busy, runahead}),
            128'(1));
      end
      head_vld = 0; head_miss = 0;
      mem_fill = 1;
      #1;
      chk(rst_wr_en === 0, "R7", "no restore before edge", 128'(rst_wr_en), 128'(0));
      tick();
      mem_fill = 0;
    end
    for (int i = 0; i < NA; i++) begin
      #1;
      chk(rst_wr_en === 1 && rst_wr_idx === AW'(i), early_fill ? "R12" : "R7",
          "restore idx", 128'({rst_wr_en, rst_wr_idx}), 128'({1'b1, AW'(i)}));
      chk(rst_wr_data === sv_arf[i] && rst_map_phys === sv_map[i], "R7", "restore data",
          128'({rst_wr_data, rst_map_phys}), 128'({sv_arf[i], sv_map[i]}));
      chk(redirect_vld === (i == NA - 1), "R8", "redirect timing", 128'(redirect_vld),
          128'(i == NA - 1));
      if (i == NA - 1) begin
        chk(redirect_pc === pc0, "R8", "redirect pc", 128'(redirect_pc), 128'(pc0));
        chk(ras_restore === ras0, "R8", "ras restore", 128'(ras_restore), 128'(ras0));
        chk(ghr_restore === ghr0, "R8", "ghr restore", 128'(ghr_restore), 128'(ghr0));
      end
      tick();
    end
    #1;
    chk(runahead === 0 && commit_block === 0, "R8", "back to normal",
        128'({runahead, commit_block}), 128'(0));
    probe(hd, 1'b0, "R9");
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++; n_run++;
        $display("FAIL watchdog act=%0d exp=<100000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    n_run = 0; n_fail = 0;
    void'($urandom(32'd1234));
    rst_n = 0; head_vld = 0; head_is_mem = 0; head_miss = 0; mem_fill = 0;
    head_pc = '0; head_dst = '0; ras_in = '0; ghr_in = '0;
    for (int i = 0; i < NA; i++) begin arf_m[i] = '0; map_m[i] = '0; end
    idle_issue();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    #1;
    chk(runahead === 0 && busy === 0 && commit_block === 0 && rst_wr_en === 0 &&
        redirect_vld === 0, "R3", "reset state",
        128'({runahead, busy, commit_block, rst_wr_en, redirect_vld}), 128'(0));
    mem_fill = 1;
    tick();
    mem_fill = 0;
    #1;
    chk(runahead === 0, "R10", "fill in normal", 128'(runahead), 128'(0));
    head_vld = 1; head_is_mem = 0; head_miss = 1;
    tick();
    #1;
    chk(runahead === 0, "R1", "non-mem miss", 128'(runahead), 128'(0));
    head_is_mem = 1; head_miss = 0;
    tick();
    #1;
    chk(runahead === 0, "R1", "mem hit", 128'(runahead), 128'(0));
    head_vld = 0; head_miss = 1;
    tick();
    #1;
    chk(runahead === 0, "R1", "invalid head", 128'(runahead), 128'(0));
    head_miss = 0;
    iss_vld = 1; iss_src0 = 7'd3; iss_src1 = 7'd3;
    #1;
    chk(iss_skip === 0, "R5", "skip in normal", 128'(iss_skip), 128'(0));
    idle_issue();
    episode(1'b0, 40);
    episode(1'b1, 0);
    episode(1'b0, 60);
    episode(1'b0, 25);
    episode(1'b1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule